// File: doc/BRIEF.md
# Mask-Selected Pin Configuration Bank

This block holds the configuration of one bank of general-purpose pins, one configuration word per pin, and reaches all of them through a single shared register address. Software first loads a pin-select mask. A later write to the shared configuration register updates every pin whose mask bit is 1. A later read of that register returns the word of one selected pin. One bus write can therefore configure any subset of the bank.

Each stored word is decoded continuously into per-pin control outputs: a function selector, direction, pull-up, pull-down, input filter enable, slow-clock filter select, open-drain enable, Schmitt control and an event-select code. A third register returns the pad input levels after a two-flop synchronizer. Banks repeat every 0x40 bytes, so the block decodes only the offset within its own window. The bus uses a single-cycle enable/write strobe, and read data is combinational from the current state.

Top module: `pcfg_bank`

## Requirements
- R1: After reset the select mask is 0, every pin's configuration word is 0 and every per-pin output is 0. This means GPIO function (code 0), input direction and no pulls.
- R2: A write to offset 0x00 loads the select mask from write-data bits [NPINS-1:0]. Bit i selects pin i. A read of 0x00 returns the mask, zero-extended.
- R3: A write to offset 0x04 updates the configuration word of every pin whose mask bit is 1, from the next cycle on. Pins whose mask bit is 0 keep their words.
- R4: Only the defined field bits are stored: bits [2:0], 8, 9, 10, 12, 13, 14, 15 and [26:24] (field mask 0x0700F707). All other bits of a stored word read as 0.
- R5: A read of offset 0x04 returns the word of the lowest-numbered pin whose mask bit is 1. With an empty mask the read returns 0.
- R6: The per-pin outputs decode each pin's word as follows. Function is bits [2:0] (0 = GPIO, 1..7 = peripheral A..G). Direction is bit 8 (1 = output). Pull-up is bit 9 and pull-down is bit 10. Filter enable is bit 12 and slow-clock filter is bit 13. Open-drain is bit 14 and Schmitt control is bit 15. Event select is bits [26:24].
- R7: A read of offset 0x08 returns pad_in as it stood two clock edges earlier, through a two-stage synchronizer. Writes to 0x08 change neither this register, the mask nor any configuration word.
- R8: Reads of any other offset return 0. Writes to any other offset change neither the mask nor any configuration word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the bank window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current state |
| pad_in | input | NPINS | Asynchronous pad input levels |
| pin_func | output | 3*NPINS | Function code, pin i at [3i+2:3i] |
| pin_dir | output | NPINS | Direction, 1 = output |
| pin_pu | output | NPINS | Pull-up enable |
| pin_pd | output | NPINS | Pull-down enable |
| pin_filt | output | NPINS | Input filter enable |
| pin_slow | output | NPINS | Slow-clock filter select |
| pin_od | output | NPINS | Open-drain enable |
| pin_schmitt | output | NPINS | Schmitt trigger control |
| pin_evsel | output | 3*NPINS | Event-select code, pin i at [3i+2:3i] |

## Verification
Several properties are checked on every cycle. Each selected pin takes the field-masked write data, and every unselected pin holds its word. The mask loads only on its own write. An empty-mask read returns zero, and a single-bit mask reads back exactly that pin's word. A status read matches the pad input from two edges earlier. Some behaviour only the bench scenarios can show. These are the lowest-pin priority when several mask bits are set, the full decode of every field onto the per-pin outputs across a sweep of all pins, and the fact that writes to the status or unmapped offsets leave the visible state untouched.

// File: rtl/pcfg_pkg.sv
`timescale 1ns/1ps
package pcfg_pkg;
  localparam int WORD_W = 32;
  localparam logic [WORD_W-1:0] FIELD_MASK = 32'h0700_F707;

  localparam int FUNC_LSB = 0;
  localparam int DIR_BIT  = 8;
  localparam int PU_BIT   = 9;
  localparam int PD_BIT   = 10;
  localparam int FILT_BIT = 12;
  localparam int SLOW_BIT = 13;
  localparam int OD_BIT   = 14;
  localparam int ST_BIT   = 15;
  localparam int EVT_LSB  = 24;

  localparam int OFS_MASK = 'h00;
  localparam int OFS_CFG  = 'h04;
  localparam int OFS_STAT = 'h08;

  typedef struct packed {
    logic [2:0] func;
    logic       dir;
    logic       pu;
    logic       pd;
    logic       filt;
    logic       slow;
    logic       od;
    logic       st;
    logic [2:0] evsel;
  } pin_cfg_t;

  function automatic logic [WORD_W-1:0] keep_fields(input logic [WORD_W-1:0] w);
    return w & FIELD_MASK;
  endfunction

  function automatic pin_cfg_t decode_word(input logic [WORD_W-1:0] w);
    pin_cfg_t c;
    c.func  = w[FUNC_LSB +: 3];
    c.dir   = w[DIR_BIT];
    c.pu    = w[PU_BIT];
    c.pd    = w[PD_BIT];
    c.filt  = w[FILT_BIT];
    c.slow  = w[SLOW_BIT];
    c.od    = w[OD_BIT];
    c.st    = w[ST_BIT];
    c.evsel = w[EVT_LSB +: 3];
    return c;
  endfunction
endpackage

// File: rtl/pcfg_sync.sv
`timescale 1ns/1ps
module pcfg_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_in;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/pcfg_word.sv
`timescale 1ns/1ps
module pcfg_word
  import pcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] word_q,
  output pin_cfg_t          cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else if (wr_en) word_q <= keep_fields(wdata);
  end

  assign cfg = decode_word(word_q);
endmodule

// File: rtl/pcfg_rdsel.sv
`timescale 1ns/1ps
module pcfg_rdsel
  import pcfg_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0]             sel,
  input  logic [NPINS-1:0][WORD_W-1:0] words,
  output logic [WORD_W-1:0]            word_out
);
  always_comb begin
    word_out = '0;
    for (int i = NPINS-1; i >= 0; i--) begin
      if (sel[i]) word_out = words[i];
    end
  end
endmodule

// File: rtl/pcfg_bank.sv
`timescale 1ns/1ps
module pcfg_bank
  import pcfg_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NPINS-1:0]    pad_in,
  output logic [3*NPINS-1:0]  pin_func,
  output logic [NPINS-1:0]    pin_dir,
  output logic [NPINS-1:0]    pin_pu,
  output logic [NPINS-1:0]    pin_pd,
  output logic [NPINS-1:0]    pin_filt,
  output logic [NPINS-1:0]    pin_slow,
  output logic [NPINS-1:0]    pin_od,
  output logic [NPINS-1:0]    pin_schmitt,
  output logic [3*NPINS-1:0]  pin_evsel
);
  logic                         hit_mask, hit_cfg, hit_stat;
  logic                         mask_wr, cfg_wr, rd_en;
  logic [NPINS-1:0]             sel_mask;
  logic [NPINS-1:0][WORD_W-1:0] cfg_words;
  logic [WORD_W-1:0]            cfg_rd_word;
  logic [NPINS-1:0]             pad_sync;
  logic [31:0]                  mask_ext, stat_ext;

  assign hit_mask = (int'(bus_addr) == OFS_MASK);
  assign hit_cfg  = (int'(bus_addr) == OFS_CFG);
  assign hit_stat = (int'(bus_addr) == OFS_STAT);
  assign mask_wr  = bus_en && bus_we && hit_mask;
  assign cfg_wr   = bus_en && bus_we && hit_cfg;
  assign rd_en    = bus_en && !bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_mask <= '0;
    else if (mask_wr) sel_mask <= bus_wdata[NPINS-1:0];
  end

  genvar p;
  generate
    for (p = 0; p < NPINS; p++) begin : g_pin
      pin_cfg_t cfg_p;
      pcfg_word u_word (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr && sel_mask[p]),
        .wdata  (bus_wdata),
        .word_q (cfg_words[p]),
        .cfg    (cfg_p)
      );
      assign pin_func[3*p +: 3]  = cfg_p.func;
      assign pin_dir[p]          = cfg_p.dir;
      assign pin_pu[p]           = cfg_p.pu;
      assign pin_pd[p]           = cfg_p.pd;
      assign pin_filt[p]         = cfg_p.filt;
      assign pin_slow[p]         = cfg_p.slow;
      assign pin_od[p]           = cfg_p.od;
      assign pin_schmitt[p]      = cfg_p.st;
      assign pin_evsel[3*p +: 3] = cfg_p.evsel;
    end
  endgenerate

  pcfg_rdsel #(.NPINS(NPINS)) u_rdsel (
    .sel      (sel_mask),
    .words    (cfg_words),
    .word_out (cfg_rd_word)
  );

  pcfg_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pad_in),
    .q_out (pad_sync)
  );

  always_comb begin
    mask_ext = '0;
    mask_ext[NPINS-1:0] = sel_mask;
    stat_ext = '0;
    stat_ext[NPINS-1:0] = pad_sync;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if (hit_mask)      bus_rdata = mask_ext;
      else if (hit_cfg)  bus_rdata = cfg_rd_word;
      else if (hit_stat) bus_rdata = stat_ext;
    end
  end
endmodule

// File: rtl/pcfg_bank_chk.sv
`timescale 1ns/1ps
module pcfg_bank_chk
  import pcfg_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_en,
  input logic                         bus_we,
  input logic                         mask_wr,
  input logic                         cfg_wr,
  input logic                         hit_cfg,
  input logic                         hit_stat,
  input logic [31:0]                  bus_wdata,
  input logic [31:0]                  bus_rdata,
  input logic [NPINS-1:0]             sel_mask,
  input logic [NPINS-1:0][WORD_W-1:0] cfg_words,
  input logic [NPINS-1:0]             pad_in
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> sel_mask == $past(bus_wdata[NPINS-1:0]));

  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(sel_mask));

  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && hit_cfg && sel_mask == '0) |-> bus_rdata == '0);

  genvar i;
  generate
    for (i = 0; i < NPINS; i++) begin : g_pin_chk
      p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && sel_mask[i]) |=> cfg_words[i] == ($past(bus_wdata) & FIELD_MASK));

      p_unsel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && sel_mask[i]) |=> $stable(cfg_words[i]));

      p_single_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && hit_cfg && sel_mask == (NPINS'(1) << i))
          |-> bus_rdata == cfg_words[i]);
    end
    if (SYNC_STAGES == 2) begin : g_stat_chk
      p_stat_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && hit_stat && since_rst >= 2'd2)
          |-> bus_rdata[NPINS-1:0] == $past(pad_in, 2));
    end
  endgenerate
endmodule

bind pcfg_bank pcfg_bank_chk #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .mask_wr   (mask_wr),
  .cfg_wr    (cfg_wr),
  .hit_cfg   (hit_cfg),
  .hit_stat  (hit_stat),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .sel_mask  (sel_mask),
  .cfg_words (cfg_words),
  .pad_in    (pad_in)
);

// File: tb/tb_pcfg_bank.sv
`timescale 1ns/1ps
module tb_pcfg_bank;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_en = 1'b0, bus_we = 1'b0;
  logic [5:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pad_in = '0;
  logic [3*N-1:0] pin_func, pin_evsel;
  logic [N-1:0]  pin_dir, pin_pu, pin_pd, pin_filt, pin_slow, pin_od, pin_schmitt;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_w [N];
  logic [31:0] exp_mask;

  always #2.5 clk = ~clk;

  pcfg_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pin_func(pin_func), .pin_dir(pin_dir), .pin_pu(pin_pu),
    .pin_pd(pin_pd), .pin_filt(pin_filt), .pin_slow(pin_slow), .pin_od(pin_od),
    .pin_schmitt(pin_schmitt), .pin_evsel(pin_evsel)
  );

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    if (a == 6'h00) exp_mask = d;
    if (a == 6'h04)
      for (int i = 0; i < N; i++)
        if (exp_mask[i]) exp_w[i] = d & 32'h0700_F707;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic chk_outputs(input string tag);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      logic [31:0] got;
      got = '0;
      got[2:0]   = pin_func[3*i +: 3];
      got[8]     = pin_dir[i];
      got[9]     = pin_pu[i];
      got[10]    = pin_pd[i];
      got[12]    = pin_filt[i];
      got[13]    = pin_slow[i];
      got[14]    = pin_od[i];
      got[15]    = pin_schmitt[i];
      got[26:24] = pin_evsel[3*i +: 3];
      check32($sformatf("%s R6 outputs pin %0d", tag, i), got, exp_w[i]);
    end
  endtask

  function automatic logic [31:0] pat(input int i, input int k);
    return (32'(i + 1) * 32'h9E37_79B1) ^ (32'(k) * 32'h7F4A_7C15) ^ 32'hFFFF_0000;
  endfunction

  initial begin
    #(5ns * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] m;
    logic [31:0] expv;
    for (int i = 0; i < N; i++) exp_w[i] = '0;
    exp_mask = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    bus_read(6'h00, rd); check32("R1 mask after reset", rd, 32'h0);
    bus_read(6'h04, rd); check32("R1 cfg read empty mask", rd, 32'h0);
    chk_outputs("R1 reset");

    // R2/R3/R4: per-pin sweep with one-hot masks
    for (int i = 0; i < N; i++) begin
      bus_write(6'h00, 32'h1 << i);
      bus_read(6'h00, rd); check32($sformatf("R2 mask readback pin %0d", i), rd, 32'h1 << i);
      bus_write(6'h04, pat(i, 0));
    end
    chk_outputs("R3 sweep");
    for (int i = 0; i < N; i++) begin
      bus_write(6'h00, 32'h1 << i);
      bus_read(6'h04, rd);
      check32($sformatf("R4 field-only word pin %0d", i), rd, pat(i, 0) & 32'h0700_F707);
    end

    // R3: multi-pin writes leave unselected pins alone
    bus_write(6'h00, 32'hA5A5_0F0F);
    bus_write(6'h04, 32'hFFFF_FFFF);
    chk_outputs("R3 multi all-ones");
    bus_write(6'h00, 32'h8000_0001);
    bus_write(6'h04, pat(5, 3));
    chk_outputs("R3 multi ends");
    bus_write(6'h00, 32'h0);
    bus_write(6'h04, 32'hFFFF_FFFF);
    chk_outputs("R3 empty-mask write");

    // R5: lowest selected pin wins; empty mask reads zero
    for (int k = 0; k < 6; k++) begin
      case (k)
        0: m = 32'h0000_0006;
        1: m = 32'h8000_0000;
        2: m = 32'hFFFF_FFFF;
        3: m = 32'h00F0_0000;
        4: m = 32'h4000_0100;
        default: m = 32'h0;
      endcase
      bus_write(6'h00, m);
      expv = '0;
      for (int i = N-1; i >= 0; i--) if (m[i]) expv = exp_w[i];
      bus_read(6'h04, rd);
      check32($sformatf("R5 priority read mask %08h", m), rd, expv);
    end

    // R7: synchronized pad status, writes ignored
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      pad_in = (k == 0) ? 32'hDEAD_BEEF : (k == 1) ? 32'h0 : 32'h1234_5678;
      repeat (3) @(posedge clk);
      bus_read(6'h08, rd); check32($sformatf("R7 status pattern %0d", k), rd, pad_in);
    end
    bus_write(6'h00, 32'h0000_0300);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 6'h08; bus_wdata = ~pad_in;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    bus_read(6'h08, rd); check32("R7 status after write", rd, pad_in);
    bus_read(6'h00, rd); check32("R7 mask after status write", rd, 32'h0000_0300);
    chk_outputs("R7 words after status write");

    // R8: unmapped offsets
    bus_read(6'h0C, rd); check32("R8 read 0x0C", rd, 32'h0);
    bus_read(6'h3C, rd); check32("R8 read 0x3C", rd, 32'h0);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 6'h0C; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_addr = 6'h10;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    bus_read(6'h00, rd); check32("R8 mask after unmapped write", rd, 32'h0000_0300);
    chk_outputs("R8 words after unmapped write");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule